// File: doc/BRIEF.md
# Parallel Printer Strobe Byte Capture

This block sits beside the register write path of a sound-generator chip whose two general-purpose I/O registers double as a parallel printer port. One register (index 15) carries the outgoing data byte; the other (index 14) carries control lines, and bit 5 of it is the printer strobe. The block keeps its own copies of both port registers. It emits a captured byte with a one-clock valid pulse when software writes the data byte and then, as its very next register write, drives the strobe low.

A two-state sequencer tracks whether the most recent register write went to the data port. State `ST_IDLE` means it did not. State `ST_ARMED` means it did. Transitions: `ARM` (any state, write to index 15 → `ST_ARMED`), `DISARM` (any state, write to any other index → `ST_IDLE`), `HOLD` (no write → same state). A write to index 14 that leaves bit 5 at 0 while in `ST_ARMED` fires a capture, provided the print enable is high. The sequencer leaves `ST_ARMED` on that write whether or not it fires. Cycles with no write do not change the state.

Top module: `prn_strobe_capture`

## Requirements
- R1: After reset, `port_a`, `port_b`, `cap_byte` and `cap_valid` are all zero and the sequencer is in `ST_IDLE`.
- R2: A write to index 15 appears on `port_b` one clock after the write is sampled.
- R3: A write to index 14 appears on `port_a` one clock after the write is sampled, whatever the level of `print_en`.
- R4: When a write to index 14 with data bit 5 equal to 0 directly follows a write to index 15 and `print_en` is high, `cap_valid` is high one clock later and `cap_byte` equals the `port_b` value held at the time of the index-14 write.
- R5: `cap_valid` is high for exactly one clock per capture.
- R6: A write to index 14 with bit 5 equal to 1 emits nothing and ends `ST_ARMED`, so a following strobe-low write also emits nothing.
- R7: A second strobe-low write to index 14 right after a capture emits nothing.
- R8: A write to any index other than 14 or 15 between the port B write and the strobe-low write prevents capture and leaves `port_a` and `port_b` unchanged.
- R9: With `print_en` low, a qualifying strobe-low write emits nothing but still updates `port_a` and still ends `ST_ARMED`.
- R10: Clock cycles with `wr_en` low between the port B write and the strobe-low write do not affect arming; the capture still fires.
- R11: `cap_byte` holds the last captured value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 8 | Data of the write |
| print_en | input | 1 | Enables emission of captured bytes |
| cap_byte | output | 8 | Last captured printer byte |
| cap_valid | output | 1 | One-clock pulse marking a new capture |
| port_a | output | 8 | Current control-port register value |
| port_b | output | 8 | Current data-port register value |

## Verification
The sequencer's one state bit can be observed only through `cap_valid`. A wrong state shows up on the first strobe-low write after the bad transition: either a pulse appears where none was due, or an expected pulse is missing, one clock after that write. The directed cases therefore place every kind of arming and disarming write right before a strobe-low write. They also check the pulse width and `cap_byte` on the clock that follows.

// File: rtl/prn_cap_pkg.sv
package prn_cap_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;
endpackage

// File: rtl/prn_port_regs.sv
module prn_port_regs #(
    parameter int IDX_W     = 4,
    parameter int DATA_W    = 8,
    parameter int PORTA_IDX = 14,
    parameter int PORTB_IDX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] porta_q,
    output logic [DATA_W-1:0] portb_q
);
    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(PORTA_IDX);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(PORTB_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            porta_q <= '0;
            portb_q <= '0;
        end else if (wr_en) begin
            if (wr_idx == IDX_A) porta_q <= wr_data;
            if (wr_idx == IDX_B) portb_q <= wr_data;
        end
    end
endmodule

// File: rtl/prn_arm_fsm.sv
module prn_arm_fsm
    import prn_cap_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int DATA_W     = 8,
    parameter int PORTA_IDX  = 14,
    parameter int PORTB_IDX  = 15,
    parameter int STROBE_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              print_en,
    output logic              fire
);
    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(PORTA_IDX);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(PORTB_IDX);

    arm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                ST_IDLE:  state_d = (wr_idx == IDX_B) ? ST_ARMED : ST_IDLE;
                ST_ARMED: state_d = (wr_idx == IDX_B) ? ST_ARMED : ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_IDLE:  fire = 1'b0;
            ST_ARMED: fire = wr_en && print_en && (wr_idx == IDX_A)
                             && !wr_data[STROBE_BIT];
            default:  fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/prn_capture_out.sv
module prn_capture_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] portb_q,
    output logic [DATA_W-1:0] cap_byte,
    output logic              cap_valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_byte  <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= fire;
            if (fire) cap_byte <= portb_q;
        end
    end
endmodule

// File: rtl/prn_strobe_capture.sv
module prn_strobe_capture #(
    parameter int IDX_W      = 4,
    parameter int DATA_W     = 8,
    parameter int PORTA_IDX  = 14,
    parameter int PORTB_IDX  = 15,
    parameter int STROBE_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              print_en,
    output logic [DATA_W-1:0] cap_byte,
    output logic              cap_valid,
    output logic [DATA_W-1:0] port_a,
    output logic [DATA_W-1:0] port_b
);
    logic fire;

    prn_port_regs #(
        .IDX_W(IDX_W), .DATA_W(DATA_W),
        .PORTA_IDX(PORTA_IDX), .PORTB_IDX(PORTB_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .porta_q(port_a), .portb_q(port_b)
    );

    prn_arm_fsm #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .PORTA_IDX(PORTA_IDX),
        .PORTB_IDX(PORTB_IDX), .STROBE_BIT(STROBE_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .print_en(print_en), .fire(fire)
    );

    prn_capture_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .fire(fire), .portb_q(port_b),
        .cap_byte(cap_byte), .cap_valid(cap_valid)
    );
endmodule

// File: rtl/prn_strobe_capture_chk.sv
module prn_strobe_capture_chk #(
    parameter int IDX_W      = 4,
    parameter int DATA_W     = 8,
    parameter int PORTA_IDX  = 14,
    parameter int PORTB_IDX  = 15,
    parameter int STROBE_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              print_en,
    input logic [DATA_W-1:0] cap_byte,
    input logic              cap_valid,
    input logic [DATA_W-1:0] port_a,
    input logic [DATA_W-1:0] port_b
);
    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(PORTA_IDX);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(PORTB_IDX);

    p_portb_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_B) |=> (port_b == $past(wr_data)));

    p_porta_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_A) |=> (port_a == $past(wr_data)));

    p_valid_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_valid) |-> ($past(wr_en) && $past(wr_idx) == IDX_A
                              && !$past(wr_data[STROBE_BIT]) && $past(print_en)));

    p_byte_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_valid) |-> (cap_byte == $past(port_b)));

    p_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !print_en |=> !cap_valid);

    p_byte_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> (cap_valid || $stable(cap_byte)));
endmodule

bind prn_strobe_capture prn_strobe_capture_chk #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .PORTA_IDX(PORTA_IDX),
    .PORTB_IDX(PORTB_IDX), .STROBE_BIT(STROBE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .print_en(print_en), .cap_byte(cap_byte),
    .cap_valid(cap_valid), .port_a(port_a), .port_b(port_b)
);

// File: tb/prn_strobe_capture_test.sv
module prn_strobe_capture_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       print_en = 1'b1;
    logic [7:0] cap_byte, port_a, port_b;
    logic       cap_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prn_strobe_capture uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .print_en(print_en), .cap_byte(cap_byte),
        .cap_valid(cap_valid), .port_a(port_a), .port_b(port_b)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Drives one write; returns at the next falling edge, when its results are visible.
    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 port_a", port_a, 0);
        check("R1 port_b", port_b, 0);
        check("R1 cap_byte", cap_byte, 0);
        check("R1 cap_valid", cap_valid, 0);
        wr(14, 8'h00);
        check("R1 idle after reset no capture", cap_valid, 0);
    endtask

    task automatic t_basic();
        wr(15, 8'hA5);
        check("R2 port_b", port_b, 8'hA5);
        check("R2 no pulse on B write", cap_valid, 0);
        wr(14, 8'hDF);
        check("R3 port_a", port_a, 8'hDF);
        check("R4 valid", cap_valid, 1);
        check("R4 byte", cap_byte, 8'hA5);
        idle(1);
        check("R5 pulse one clock", cap_valid, 0);
        check("R11 byte held", cap_byte, 8'hA5);
    endtask

    task automatic t_second_low();
        wr(15, 8'h3C);
        wr(14, 8'h00);
        check("R4 valid second byte", cap_valid, 1);
        check("R4 byte second", cap_byte, 8'h3C);
        wr(14, 8'h00);
        check("R7 repeat strobe low", cap_valid, 0);
        check("R11 byte held", cap_byte, 8'h3C);
    endtask

    task automatic t_strobe_high();
        wr(15, 8'h77);
        wr(14, 8'h20);
        check("R6 strobe high no capture", cap_valid, 0);
        wr(14, 8'h00);
        check("R6 disarmed after strobe high", cap_valid, 0);
        check("R11 byte held", cap_byte, 8'h3C);
    endtask

    task automatic t_other_idx();
        wr(14, 8'h20);
        wr(15, 8'h5A);
        wr(3, 8'hFF);
        check("R8 port_a unchanged", port_a, 8'h20);
        check("R8 port_b unchanged", port_b, 8'h5A);
        wr(14, 8'h00);
        check("R8 other write disarms", cap_valid, 0);
    endtask

    task automatic t_disabled();
        wr(15, 8'h81);
        print_en = 1'b0;
        wr(14, 8'h11);
        check("R9 no capture when disabled", cap_valid, 0);
        check("R9 port_a still written", port_a, 8'h11);
        print_en = 1'b1;
        wr(14, 8'h01);
        check("R9 flag consumed", cap_valid, 0);
        check("R11 byte held", cap_byte, 8'h3C);
    endtask

    task automatic t_gaps();
        wr(15, 8'hE4);
        idle(3);
        wr(14, 8'h00);
        check("R10 fires after idle gap", cap_valid, 1);
        check("R10 byte", cap_byte, 8'hE4);
        idle(1);
        check("R5 pulse one clock", cap_valid, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_second_low();
        t_strobe_high();
        t_other_idx();
        t_disabled();
        t_gaps();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule